// File: doc/BRIEF.md
# Register Job Requester

This block is the master side of a small register access link. A local agent issues a single read or write command (a one-cycle strobe with direction, a 4-bit register index and, for writes, a data byte). The requester turns it into a framed request job on an outbound byte stream, then consumes the framed response on an inbound byte stream. It finishes with a one-cycle completion pulse that carries an error flag and, for reads, the returned byte.

Both streams carry a byte plus first-beat and last-beat flags and use valid/ready transfer rules. A beat moves on a rising edge where valid and ready are both high. On the outbound side the requester holds the whole beat steady while the responder applies back-pressure by keeping ready low. On the inbound side the requester raises ready for the whole time it waits for a response beat. Only one job can be outstanding at a time.

Top module: `regjob_requester`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `req_valid_o`, `rsp_ready_o` and `done_o` all low, and any job in flight is dropped.
- R2: A read command taken from idle puts, one cycle after the strobe, a single beat on the request stream. This beat has first and last flags both set and the byte `{addr, 4'h0}`: the index is in bits 7:4 and code 0 in bits 3:0.
- R3: A write command produces two beats. The first has the first flag set, the last flag clear and the byte `{addr, 4'h1}`. After that beat is taken, the second beat follows with the first flag clear, the last flag set and the write byte.
- R4: While `req_valid_o` is high and `req_ready_i` is low, valid, both flags and the byte stay unchanged. `req_valid_o` falls in the cycle after the last beat of the job is taken. The flags are never set while valid is low.
- R5: `rsp_ready_o` is high from the cycle after a command is taken until the footer beat is taken, and low in the cycle where `done_o` is high and whenever no job is in flight.
- R6: For a read, the response parser expects a header beat (first flag), then a data beat (neither flag), then a footer beat (last flag). It copies the data beat byte to `rdata_o`.
- R7: For a write, the parser expects a header beat followed directly by a footer beat, and leaves `rdata_o` unchanged.
- R8: `done_o` is high for exactly one cycle, the cycle after the footer is taken. `err_o` is 0 when the footer byte is 8'h00 and 1 for any other value (8'h01 is the error code), and it holds until the next completion.
- R9: Any number of cycles with `rsp_valid_i` low between response beats leaves the job open, with `rsp_ready_o` still high and no completion.
- R10: A command strobe while a job is in flight is ignored: the beat on the request stream is unchanged, and no further job is issued once the current one ends.
- R11: While the parser waits for the header, an inbound beat without the first flag is taken and dropped, with no completion and no change to the job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_start_i | input | 1 | One-cycle command strobe |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | ADDR_W | Register index |
| cmd_wdata_i | input | DATA_W | Write byte |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Byte returned by the last read |
| err_o | output | 1 | Error flag of the last completion |
| req_valid_o | output | 1 | Request beat valid |
| req_ready_i | input | 1 | Responder takes the request beat |
| req_first_o | output | 1 | Request beat is the header |
| req_last_o | output | 1 | Request beat ends the job |
| req_data_o | output | DATA_W | Request beat byte |
| rsp_valid_i | input | 1 | Response beat valid |
| rsp_ready_o | output | 1 | Requester takes the response beat |
| rsp_first_i | input | 1 | Response beat is the header |
| rsp_last_i | input | 1 | Response beat is the footer |
| rsp_data_i | input | DATA_W | Response beat byte |

## Verification
The bench builds the requester with its defaults, a 4-bit index and an 8-bit byte. This lets it issue jobs to every index from 0 to 15 and model a responder that returns the error footer for indices above 7. The same bench walks a vector table in which each job has its own stall count, from none to three cycles. That count drives both the back-pressure on the request beats and the idle gaps between response beats, so the hold rule and the gap tolerance are reached at several lengths. Directed cases then cover reset in mid-job, a strobe while busy and a stray beat before the header.

// File: rtl/regjob_pkg.sv
package regjob_pkg;
  localparam int unsigned CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_RD = 4'h0;
  localparam logic [CMD_W-1:0] CMD_WR = 4'h1;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_HDR,
    TX_DATA
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_OFF,
    RX_HDR,
    RX_DATA,
    RX_FTR
  } rx_state_e;
endpackage

// File: rtl/regjob_tx.sv
module regjob_tx
  import regjob_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic              first_o,
  output logic              last_o,
  output logic [DATA_W-1:0] data_o
);
  tx_state_e         state_q;
  logic [DATA_W-1:0] wdata_q;
  logic              is_wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      valid_o <= 1'b0;
      first_o <= 1'b0;
      last_o  <= 1'b0;
      data_o  <= '0;
      wdata_q <= '0;
      is_wr_q <= 1'b0;
    end else begin
      case (state_q)
        TX_IDLE: begin
          if (launch_i) begin
            state_q <= TX_HDR;
            valid_o <= 1'b1;
            first_o <= 1'b1;
            last_o  <= !write_i;
            data_o  <= {addr_i, (write_i ? CMD_WR : CMD_RD)};
            wdata_q <= wdata_i;
            is_wr_q <= write_i;
          end
        end
        TX_HDR: begin
          if (ready_i) begin
            first_o <= 1'b0;
            if (is_wr_q) begin
              state_q <= TX_DATA;
              last_o  <= 1'b1;
              data_o  <= wdata_q;
            end else begin
              state_q <= TX_IDLE;
              valid_o <= 1'b0;
              last_o  <= 1'b0;
            end
          end
        end
        TX_DATA: begin
          if (ready_i) begin
            state_q <= TX_IDLE;
            valid_o <= 1'b0;
            last_o  <= 1'b0;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regjob_rx.sv
module regjob_rx
  import regjob_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              arm_read_i,
  input  logic              valid_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] FTR_OK = '0;

  rx_state_e state_q;
  logic      is_rd_q;
  logic      take;
  logic      ftr_bad;

  assign ready_o = (state_q != RX_OFF);
  assign take    = valid_i && ready_o;
  assign ftr_bad = (data_i != FTR_OK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RX_OFF;
      is_rd_q <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        RX_OFF: begin
          if (arm_i) begin
            state_q <= RX_HDR;
            is_rd_q <= arm_read_i;
          end
        end
        RX_HDR: begin
          if (take && first_i) begin
            state_q <= is_rd_q ? RX_DATA : RX_FTR;
          end
        end
        RX_DATA: begin
          if (take && !first_i) begin
            if (last_i) begin
              state_q <= RX_OFF;
              done_o  <= 1'b1;
              err_o   <= ftr_bad;
            end else begin
              state_q <= RX_FTR;
              rdata_o <= data_i;
            end
          end
        end
        RX_FTR: begin
          if (take && last_i && !first_i) begin
            state_q <= RX_OFF;
            done_o  <= 1'b1;
            err_o   <= ftr_bad;
          end
        end
        default: state_q <= RX_OFF;
      endcase
    end
  end
endmodule

// File: rtl/regjob_requester.sv
module regjob_requester
  import regjob_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start_i,
  input  logic              cmd_write_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_first_o,
  output logic              req_last_o,
  output logic [DATA_W-1:0] req_data_o,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic              rsp_first_i,
  input  logic              rsp_last_i,
  input  logic [DATA_W-1:0] rsp_data_i
);
  localparam int unsigned HDR_W = ADDR_W + CMD_W;

  generate
    if (HDR_W != DATA_W) begin : g_bad_width
      $error("header needs ADDR_W + CMD_W == DATA_W");
    end
  endgenerate

  logic launch;
  logic busy;

  // One job at a time: the parser stays armed from launch until footer.
  assign busy   = rsp_ready_o;
  assign launch = cmd_start_i && !busy;

  regjob_tx #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch_i(launch),
    .write_i (cmd_write_i),
    .addr_i  (cmd_addr_i),
    .wdata_i (cmd_wdata_i),
    .ready_i (req_ready_i),
    .valid_o (req_valid_o),
    .first_o (req_first_o),
    .last_o  (req_last_o),
    .data_o  (req_data_o)
  );

  regjob_rx #(
    .DATA_W(DATA_W)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (launch),
    .arm_read_i(!cmd_write_i),
    .valid_i   (rsp_valid_i),
    .first_i   (rsp_first_i),
    .last_i    (rsp_last_i),
    .data_i    (rsp_data_i),
    .ready_o   (rsp_ready_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/regjob_requester_chk.sv
module regjob_requester_chk
  import regjob_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_start_i,
  input logic              cmd_write_i,
  input logic [ADDR_W-1:0] cmd_addr_i,
  input logic [DATA_W-1:0] cmd_wdata_i,
  input logic              done_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic              req_first_o,
  input logic              req_last_o,
  input logic [DATA_W-1:0] req_data_o,
  input logic              rsp_valid_i,
  input logic              rsp_ready_o,
  input logic              rsp_first_i,
  input logic              rsp_last_i,
  input logic [DATA_W-1:0] rsp_data_i
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!req_valid_o && !rsp_ready_o && !done_o));

  // R2
  rd_header_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_first_o && req_last_o) |-> (req_data_o[CMD_W-1:0] == CMD_RD));

  // R3
  wr_header_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_first_o && !req_last_o) |-> (req_data_o[CMD_W-1:0] == CMD_WR));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_first_o) && $stable(req_last_o) && $stable(req_data_o)));

  // R4
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_first_o || req_last_o) |-> req_valid_o);

  // R5
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> rsp_ready_o);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rsp_ready_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind regjob_requester regjob_requester_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/regjob_requester_tb_top.sv
module regjob_requester_tb_top;
  typedef struct packed {
    logic       wr;
    logic [3:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [3:0] gap;
    logic       exp_err;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd3,  8'h00, 8'hA5, 4'd0, 1'b0},
    '{1'b1, 4'd5,  8'h3C, 8'h00, 4'd2, 1'b0},
    '{1'b0, 4'd9,  8'h00, 8'h00, 4'd1, 1'b1},
    '{1'b1, 4'd15, 8'h77, 8'h00, 4'd0, 1'b1},
    '{1'b0, 4'd7,  8'h00, 8'h5A, 4'd3, 1'b0},
    '{1'b1, 4'd0,  8'hFF, 8'h00, 4'd1, 1'b0},
    '{1'b0, 4'd0,  8'h00, 8'h81, 4'd0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_start_i = 1'b0, cmd_write_i = 1'b0;
  logic [3:0] cmd_addr_i = '0;
  logic [7:0] cmd_wdata_i = '0;
  logic       done_o, err_o;
  logic [7:0] rdata_o;
  logic       req_valid_o, req_first_o, req_last_o;
  logic       req_ready_i = 1'b0;
  logic [7:0] req_data_o;
  logic       rsp_valid_i = 1'b0, rsp_first_i = 1'b0, rsp_last_i = 1'b0;
  logic       rsp_ready_o;
  logic [7:0] rsp_data_i = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  regjob_requester dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_start_i(cmd_start_i), .cmd_write_i(cmd_write_i),
    .cmd_addr_i(cmd_addr_i), .cmd_wdata_i(cmd_wdata_i),
    .done_o(done_o), .rdata_o(rdata_o), .err_o(err_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_first_o(req_first_o), .req_last_o(req_last_o), .req_data_o(req_data_o),
    .rsp_valid_i(rsp_valid_i), .rsp_ready_o(rsp_ready_o),
    .rsp_first_i(rsp_first_i), .rsp_last_i(rsp_last_i), .rsp_data_i(rsp_data_i)
  );

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send_beat(input logic f, input logic l, input logic [7:0] d, input int gap, input string tag);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      chk(rsp_ready_o === 1'b1 && done_o === 1'b0, "R9 gap keeps job open",
          {14'd0, rsp_ready_o, done_o}, 16'h0002);
    end
    rsp_valid_i = 1'b1; rsp_first_i = f; rsp_last_i = l; rsp_data_i = d;
    @(negedge clk);
    rsp_valid_i = 1'b0; rsp_first_i = 1'b0; rsp_last_i = 1'b0;
    if (!l) chk(done_o === 1'b0, tag, {15'd0, done_o}, 16'h0000);
  endtask

  task automatic run_job(input vec_t v, input logic poke_busy);
    logic [7:0] hdr;
    hdr = {v.addr, (v.wr ? 4'h1 : 4'h0)};
    @(negedge clk);
    cmd_start_i = 1'b1; cmd_write_i = v.wr; cmd_addr_i = v.addr; cmd_wdata_i = v.wdata;
    @(negedge clk);
    cmd_start_i = 1'b0;
    chk(req_valid_o === 1'b1 && req_first_o === 1'b1 && req_last_o === !v.wr,
        v.wr ? "R3 write header flags" : "R2 read beat flags",
        {13'd0, req_valid_o, req_first_o, req_last_o}, {13'd0, 1'b1, 1'b1, !v.wr});
    chk(req_data_o === hdr, v.wr ? "R3 write header byte" : "R2 read header byte",
        {8'd0, req_data_o}, {8'd0, hdr});
    chk(rsp_ready_o === 1'b1, "R5 ready after launch", {15'd0, rsp_ready_o}, 16'h0001);
    for (int i = 0; i < int'(v.gap); i++) begin
      if (poke_busy && i == 0) begin
        cmd_start_i = 1'b1; cmd_write_i = !v.wr; cmd_addr_i = ~v.addr;
      end
      @(negedge clk);
      cmd_start_i = 1'b0;
      chk(req_valid_o === 1'b1 && req_first_o === 1'b1 && req_data_o === hdr,
          poke_busy ? "R10 busy strobe ignored" : "R4 header held under stall",
          {7'd0, req_valid_o, req_data_o}, {7'd0, 1'b1, hdr});
    end
    req_ready_i = 1'b1;
    @(negedge clk);
    if (v.wr) begin
      chk(req_valid_o === 1'b1 && req_first_o === 1'b0 && req_last_o === 1'b1 && req_data_o === v.wdata,
          "R3 write data beat", {5'd0, req_valid_o, req_first_o, req_last_o, req_data_o},
          {5'd0, 3'b101, v.wdata});
      @(negedge clk);
    end
    req_ready_i = 1'b0;
    chk(req_valid_o === 1'b0, "R4 valid falls after last beat", {15'd0, req_valid_o}, 16'h0000);
    send_beat(1'b1, 1'b0, hdr, int'(v.gap), "R6 no done after header");
    if (!v.wr) send_beat(1'b0, 1'b0, v.rdata, int'(v.gap), "R6 no done after data");
    send_beat(1'b0, 1'b1, v.exp_err ? 8'h01 : 8'h00, int'(v.gap), "R8 footer");
    chk(done_o === 1'b1, v.wr ? "R7 write done" : "R6 read done", {15'd0, done_o}, 16'h0001);
    chk(err_o === v.exp_err, "R8 error from footer", {15'd0, err_o}, {15'd0, v.exp_err});
    if (!v.wr) chk(rdata_o === v.rdata, "R6 read data", {8'd0, rdata_o}, {8'd0, v.rdata});
    @(negedge clk);
    chk(done_o === 1'b0 && rsp_ready_o === 1'b0, "R8 done single cycle, R5 idle",
        {14'd0, done_o, rsp_ready_o}, 16'h0000);
    if (poke_busy) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(req_valid_o === 1'b0, "R10 no second job", {15'd0, req_valid_o}, 16'h0000);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R8 act=hung exp=complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] kept;
    repeat (3) @(negedge clk);
    chk(req_valid_o === 1'b0 && rsp_ready_o === 1'b0 && done_o === 1'b0, "R1 reset state",
        {13'd0, req_valid_o, rsp_ready_o, done_o}, 16'h0000);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) run_job(VECS[k], 1'b0);

    // R7: a write completion leaves the last read byte in place
    kept = rdata_o;
    run_job('{1'b1, 4'd2, 8'h11, 8'h00, 4'd0, 1'b0}, 1'b0);
    chk(rdata_o === kept, "R7 rdata kept on write", {8'd0, rdata_o}, {8'd0, kept});

    // R10: strobe while busy
    run_job('{1'b0, 4'd6, 8'h00, 8'hC3, 4'd2, 1'b0}, 1'b1);

    // R11: stray beat before header
    @(negedge clk);
    cmd_start_i = 1'b1; cmd_write_i = 1'b1; cmd_addr_i = 4'd4; cmd_wdata_i = 8'h42;
    @(negedge clk);
    cmd_start_i = 1'b0; req_ready_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    req_ready_i = 1'b0;
    send_beat(1'b0, 1'b1, 8'h00, 0, "R11 stray beat dropped");
    chk(rsp_ready_o === 1'b1, "R11 job still open", {15'd0, rsp_ready_o}, 16'h0001);
    send_beat(1'b1, 1'b0, 8'h41, 0, "R11 header after stray");
    send_beat(1'b0, 1'b1, 8'h01, 1, "R11 footer");
    chk(done_o === 1'b1 && err_o === 1'b1, "R11 done from real footer",
        {14'd0, done_o, err_o}, 16'h0003);

    // R1: reset in mid-job
    @(negedge clk);
    cmd_start_i = 1'b1; cmd_write_i = 1'b0; cmd_addr_i = 4'd1;
    @(negedge clk);
    cmd_start_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_valid_o === 1'b0 && rsp_ready_o === 1'b0 && done_o === 1'b0, "R1 reset mid-job",
        {13'd0, req_valid_o, rsp_ready_o, done_o}, 16'h0000);
    rst_n = 1'b1;
    run_job('{1'b0, 4'd1, 8'h00, 8'h9E, 4'd1, 1'b0}, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule